// File: doc/BRIEF.md
# Guest Privileged-Instruction Trap Checker

This block sits beside the instruction pipeline of a processor that supports hardware virtualization. For each privileged instruction handed to it, it decides whether that instruction must trap. It receives an already decoded instruction class, the current privilege level together with the virtualization state, the hypervisor trap-control bits and the machine-level WFI trap bit. It reports either an illegal-instruction exception (cause 2) or a virtual-instruction exception (cause 22) one clock later. It never reports both.

Most rules are static: they depend only on the class, the mode and the control bits present on the issue cycle. A wait-for-interrupt executed by a guest kernel is handled differently. It may complete normally, and it traps only if it is still stalled after a bounded number of cycles. An internal counter watches the stall strobe for this purpose. The counter restarts when an interrupt wakes the hart or when the stall is abandoned.

Top module: `vtrap_check`

## Requirements
- R1: After synchronous reset, `exc_valid` is 0 and `exc_cause` is 0.
- R2: An SRET (class 1) issued in virtual supervisor mode (mode 5) while `vtsr`=1 yields `exc_valid`=1 with cause 22 on the following cycle. With `vtsr`=0 it yields no exception.
- R3: An SFENCE.VMA (class 3) or an address-translation CSR access (class 4) issued in mode 5 while `vtvm`=1 yields cause 22 on the following cycle. With `vtvm`=0 neither traps.
- R4: In user mode (mode 0) with `hu`=0, both hypervisor load/store (class 5) and other hypervisor instructions (class 6) yield cause 2 on the following cycle.
- R5: In user mode with `hu`=1, class 5 raises no exception. Class 6 still yields cause 2.
- R6: In hypervisor-supervisor mode (mode 1) and machine mode (mode 3), the bits `vtsr`, `vtvm` and `vtw` have no effect. SRET, SFENCE.VMA, class 4 and a held `wfi_wait` raise nothing there.
- R7: A WFI (class 2) issued in any mode other than 3 while `m_tw`=1 yields cause 2 on the following cycle. In that state the guest WFI timer is disarmed, even in mode 5 with `vtw`=1.
- R8: In mode 5 with `vtw`=1 and `m_tw`=0, holding `wfi_wait`=1 with `wfi_wake`=0 for `WFI_LIMIT` consecutive clock edges yields a single cause-22 pulse right after the last of those edges. Nothing is reported earlier, and nothing more is reported while the wait continues.
- R9: A cycle with `wfi_wake`=1, or a cycle with `wfi_wait`=0, restarts the timeout. A full `WFI_LIMIT` edges of uninterrupted waiting are needed again before cause 22 appears.
- R10: `exc_valid` and `exc_cause` are registered. Whenever `exc_valid`=1, the cause is exactly 2 or 22. Whenever `exc_valid`=0, the cause is 0. Static rules take precedence over a timer expiry that lands on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A decoded instruction is presented this cycle |
| op_class | input | 3 | 0 other, 1 SRET, 2 WFI, 3 SFENCE.VMA, 4 translation CSR access, 5 hypervisor load/store, 6 other hypervisor instruction |
| cur_mode | input | 3 | 0 U, 1 HS, 3 M, 4 VU, 5 VS |
| vtsr | input | 1 | Trap guest SRET |
| vtw | input | 1 | Time-limit guest WFI |
| vtvm | input | 1 | Trap guest translation management |
| hu | input | 1 | Allow hypervisor load/store in user mode |
| m_tw | input | 1 | Machine-level WFI trap |
| wfi_wait | input | 1 | A WFI is stalled this cycle |
| wfi_wake | input | 1 | A pending interrupt completes the WFI |
| exc_valid | output | 1 | Exception reported |
| exc_cause | output | 5 | 2 illegal, 22 virtual instruction, else 0 |

## Verification
The hardest situation to reach is the timer boundary: the exact edge where a guest WFI has waited `WFI_LIMIT` cycles, and the restart of that count by a wake or a one-cycle drop of the stall. The stimulus holds the stall strobe from a recorded cycle. It queues an expectation of silence on the cycle before expiry, the pulse on the expiry cycle, and silence afterwards. It then repeats the run with a wake or a gap inserted partway through, and expects silence at the original expiry point and the pulse a full limit after the interruption. Runs with `m_tw` set or in host mode check that the same held strobe never fires.

// File: rtl/vtrap_pkg.sv
`timescale 1ns/1ps
package vtrap_pkg;

    typedef enum logic [2:0] {
        OP_OTHER  = 3'd0,
        OP_SRET   = 3'd1,
        OP_WFI    = 3'd2,
        OP_SFENCE = 3'd3,
        OP_SATP   = 3'd4,
        OP_HLS    = 3'd5,
        OP_HYP    = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        MODE_U  = 3'd0,
        MODE_HS = 3'd1,
        MODE_M  = 3'd3,
        MODE_VU = 3'd4,
        MODE_VS = 3'd5
    } mode_e;

    localparam int          CAUSE_W       = 5;
    localparam logic [4:0]  CAUSE_ILLEGAL = 5'd2;
    localparam logic [4:0]  CAUSE_VIRT    = 5'd22;

    typedef struct packed {
        logic                 vld;
        logic [CAUSE_W-1:0]   cause;
    } exc_t;

    localparam exc_t EXC_NONE = '{vld: 1'b0, cause: '0};

    function automatic exc_t mk_exc(input logic [CAUSE_W-1:0] c);
        exc_t e;
        e.vld   = 1'b1;
        e.cause = c;
        return e;
    endfunction

    function automatic logic is_guest_sup(input logic [2:0] m);
        return m == MODE_VS;
    endfunction

    function automatic logic below_machine(input logic [2:0] m);
        return m != MODE_M;
    endfunction

endpackage

// File: rtl/vtrap_static_rules.sv
`timescale 1ns/1ps
module vtrap_static_rules
    import vtrap_pkg::*;
(
    input  logic        op_valid,
    input  logic [2:0]  op_class,
    input  logic [2:0]  cur_mode,
    input  logic        vtsr,
    input  logic        vtvm,
    input  logic        hu,
    input  logic        m_tw,
    output exc_t        res
);
    always_comb begin
        res = EXC_NONE;
        if (op_valid) begin
            case (op_class)
                OP_WFI: begin
                    if (below_machine(cur_mode) && m_tw)
                        res = mk_exc(CAUSE_ILLEGAL);
                end
                OP_SRET: begin
                    if (is_guest_sup(cur_mode) && vtsr)
                        res = mk_exc(CAUSE_VIRT);
                end
                OP_SFENCE, OP_SATP: begin
                    if (is_guest_sup(cur_mode) && vtvm)
                        res = mk_exc(CAUSE_VIRT);
                end
                OP_HLS: begin
                    if (cur_mode == MODE_U && !hu)
                        res = mk_exc(CAUSE_ILLEGAL);
                end
                OP_HYP: begin
                    if (cur_mode == MODE_U)
                        res = mk_exc(CAUSE_ILLEGAL);
                end
                default: res = EXC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/vtrap_wfi_timer.sv
`timescale 1ns/1ps
module vtrap_wfi_timer
    import vtrap_pkg::*;
#(
    parameter int LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cur_mode,
    input  logic        vtw,
    input  logic        m_tw,
    input  logic        wfi_wait,
    input  logic        wfi_wake,
    output logic        fire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;
    logic          spent;
    logic          armed;

    assign armed = wfi_wait && is_guest_sup(cur_mode) && vtw && !m_tw;
    assign fire  = armed && !wfi_wake && !spent && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            spent <= 1'b0;
        end else if (!armed || wfi_wake) begin
            cnt   <= '0;
            spent <= 1'b0;
        end else if (spent) begin
            cnt   <= cnt;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            spent <= 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vtrap_merge.sv
`timescale 1ns/1ps
module vtrap_merge
    import vtrap_pkg::*;
(
    input  exc_t  stat,
    input  logic  timer_fire,
    output exc_t  outv
);
    always_comb begin
        if (stat.vld)
            outv = stat;
        else if (timer_fire)
            outv = mk_exc(CAUSE_VIRT);
        else
            outv = EXC_NONE;
    end
endmodule

// File: rtl/vtrap_check.sv
`timescale 1ns/1ps
module vtrap_check
    import vtrap_pkg::*;
#(
    parameter int WFI_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  op_class,
    input  logic [2:0]  cur_mode,
    input  logic        vtsr,
    input  logic        vtw,
    input  logic        vtvm,
    input  logic        hu,
    input  logic        m_tw,
    input  logic        wfi_wait,
    input  logic        wfi_wake,
    output logic        exc_valid,
    output logic [4:0]  exc_cause
);
    exc_t stat_res;
    exc_t merged;
    logic tmo;
    exc_t exc_q;

    vtrap_static_rules u_rules (
        .op_valid (op_valid),
        .op_class (op_class),
        .cur_mode (cur_mode),
        .vtsr     (vtsr),
        .vtvm     (vtvm),
        .hu       (hu),
        .m_tw     (m_tw),
        .res      (stat_res)
    );

    vtrap_wfi_timer #(.LIMIT(WFI_LIMIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .cur_mode (cur_mode),
        .vtw      (vtw),
        .m_tw     (m_tw),
        .wfi_wait (wfi_wait),
        .wfi_wake (wfi_wake),
        .fire     (tmo)
    );

    vtrap_merge u_merge (
        .stat       (stat_res),
        .timer_fire (tmo),
        .outv       (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) exc_q <= EXC_NONE;
        else     exc_q <= merged;
    end

    assign exc_valid = exc_q.vld;
    assign exc_cause = exc_q.cause;
endmodule

// File: rtl/vtrap_check_sva.sv
`timescale 1ns/1ps
module vtrap_check_sva
    import vtrap_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_class,
    input logic [2:0]  cur_mode,
    input logic        vtsr,
    input logic        vtvm,
    input logic        hu,
    input logic        m_tw,
    input logic        exc_valid,
    input logic [4:0]  exc_cause
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !exc_valid && exc_cause == 5'd0); // R1

    AST_SRET_GUEST: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_class == OP_SRET && cur_mode == MODE_VS && vtsr
        |=> exc_valid && exc_cause == CAUSE_VIRT); // R2

    AST_FENCE_GUEST: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_class == OP_SFENCE || op_class == OP_SATP) && cur_mode == MODE_VS && vtvm
        |=> exc_valid && exc_cause == CAUSE_VIRT); // R3

    AST_USER_HYP: assert property (@(posedge clk) disable iff (rst)
        op_valid && cur_mode == MODE_U && (op_class == OP_HYP || (op_class == OP_HLS && !hu))
        |=> exc_valid && exc_cause == CAUSE_ILLEGAL); // R4

    AST_USER_HLS_OK: assert property (@(posedge clk) disable iff (rst)
        op_valid && cur_mode == MODE_U && op_class == OP_HLS && hu
        |=> !exc_valid); // R5

    AST_MACHINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        op_valid && cur_mode == MODE_M |=> !exc_valid); // R6

    AST_TW_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_class == OP_WFI && cur_mode != MODE_M && m_tw
        |=> exc_valid && exc_cause == CAUSE_ILLEGAL); // R7

    AST_CAUSE_PAIR: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (exc_cause == CAUSE_ILLEGAL || exc_cause == CAUSE_VIRT)); // R10

    AST_CAUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> exc_cause == 5'd0); // R10
endmodule

bind vtrap_check vtrap_check_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_class  (op_class),
    .cur_mode  (cur_mode),
    .vtsr      (vtsr),
    .vtvm      (vtvm),
    .hu        (hu),
    .m_tw      (m_tw),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause)
);

// File: tb/vtrap_check_test.sv
`timescale 1ns/1ps
module vtrap_check_test;
    localparam int LIMIT = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [2:0] op_class = 3'd0;
    logic [2:0] cur_mode = 3'd1;
    logic vtsr = 0, vtw = 0, vtvm = 0, hu = 0, m_tw = 0;
    logic wfi_wait = 0, wfi_wake = 0;
    logic exc_valid;
    logic [4:0] exc_cause;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int         due;
        bit         vld;
        logic [4:0] cause;
        string      req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vtrap_check #(.WFI_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
        .cur_mode(cur_mode), .vtsr(vtsr), .vtw(vtw), .vtvm(vtvm), .hu(hu),
        .m_tw(m_tw), .wfi_wait(wfi_wait), .wfi_wake(wfi_wake),
        .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    function automatic void expect_at(int due, bit v, logic [4:0] c, string r);
        item_t it;
        it.due = due; it.vld = v; it.cause = c; it.req = r;
        sb.push_back(it);
    endfunction

    // monitor: compares queued expectations on their due cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (it.due != cyc || exc_valid !== it.vld || exc_cause !== it.cause) begin
                n_bad++;
                $display("FAIL %s cyc=%0d: got vld=%0b cause=%0d, expected vld=%0b cause=%0d",
                         it.req, cyc, exc_valid, exc_cause, it.vld, it.cause);
            end
        end
    end

    task automatic set_ctl(input logic [2:0] m, input bit s, input bit w, input bit v,
                           input bit h, input bit t);
        cur_mode = m; vtsr = s; vtw = w; vtvm = v; hu = h; m_tw = t;
    endtask

    // driver: issue one instruction, expect result next cycle
    task automatic issue(input logic [2:0] cls, input bit v, input logic [4:0] c, input string r);
        @(negedge clk);
        op_valid = 1'b1;
        op_class = cls;
        expect_at(cyc + 1, v, c, r);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got no finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_at(cyc, 0, 5'd0, "R1 reset");
        idle(1);

        // R2
        set_ctl(3'd5, 1, 0, 0, 0, 0);
        issue(3'd1, 1, 5'd22, "R2 sret vtsr");
        set_ctl(3'd5, 0, 0, 0, 0, 0);
        issue(3'd1, 0, 5'd0, "R2 sret no vtsr");

        // R3
        set_ctl(3'd5, 0, 0, 1, 0, 0);
        issue(3'd3, 1, 5'd22, "R3 sfence vtvm");
        issue(3'd4, 1, 5'd22, "R3 satp vtvm");
        set_ctl(3'd5, 0, 0, 0, 0, 0);
        issue(3'd3, 0, 5'd0, "R3 sfence no vtvm");
        issue(3'd4, 0, 5'd0, "R3 satp no vtvm");

        // R4
        set_ctl(3'd0, 0, 0, 0, 0, 0);
        issue(3'd5, 1, 5'd2, "R4 hls hu=0");
        issue(3'd6, 1, 5'd2, "R4 hyp hu=0");

        // R5
        set_ctl(3'd0, 0, 0, 0, 1, 0);
        issue(3'd5, 0, 5'd0, "R5 hls hu=1");
        issue(3'd6, 1, 5'd2, "R5 hyp hu=1");

        // R6
        set_ctl(3'd1, 1, 1, 1, 0, 0);
        issue(3'd1, 0, 5'd0, "R6 hs sret");
        issue(3'd3, 0, 5'd0, "R6 hs sfence");
        issue(3'd4, 0, 5'd0, "R6 hs satp");
        set_ctl(3'd3, 1, 1, 1, 0, 1);
        issue(3'd1, 0, 5'd0, "R6 m sret");
        issue(3'd2, 0, 5'd0, "R6 m wfi with m_tw");
        set_ctl(3'd1, 1, 1, 1, 0, 0);
        @(negedge clk);
        wfi_wait = 1'b1;
        c0 = cyc;
        expect_at(c0 + LIMIT, 0, 5'd0, "R6 hs wait no timer");
        expect_at(c0 + LIMIT + 1, 0, 5'd0, "R6 hs wait no timer");
        idle(LIMIT + 2);
        wfi_wait = 1'b0;

        // R7
        set_ctl(3'd5, 0, 1, 0, 0, 1);
        issue(3'd2, 1, 5'd2, "R7 vs wfi m_tw");
        set_ctl(3'd0, 0, 0, 0, 0, 1);
        issue(3'd2, 1, 5'd2, "R7 u wfi m_tw");
        set_ctl(3'd5, 0, 1, 0, 0, 1);
        @(negedge clk);
        wfi_wait = 1'b1;
        c0 = cyc;
        expect_at(c0 + LIMIT, 0, 5'd0, "R7 timer disarmed");
        idle(LIMIT + 2);
        wfi_wait = 1'b0;

        // R8: clean expiry
        set_ctl(3'd5, 0, 1, 0, 0, 0);
        @(negedge clk);
        wfi_wait = 1'b1;
        c0 = cyc;
        expect_at(c0 + LIMIT - 1, 0, 5'd0, "R8 before limit");
        expect_at(c0 + LIMIT, 1, 5'd22, "R8 at limit");
        expect_at(c0 + LIMIT + 1, 0, 5'd0, "R8 single pulse");
        expect_at(c0 + 2 * LIMIT + 1, 0, 5'd0, "R8 no refire");
        idle(2 * LIMIT + 2);
        wfi_wait = 1'b0;
        idle(2);

        // R9: wake restarts
        @(negedge clk);
        wfi_wait = 1'b1;
        c0 = cyc;
        idle(LIMIT / 2);
        wfi_wake = 1'b1;
        @(negedge clk);
        wfi_wake = 1'b0;
        expect_at(c0 + LIMIT, 0, 5'd0, "R9 wake restart early");
        expect_at(c0 + LIMIT / 2 + 1 + LIMIT - 1, 0, 5'd0, "R9 wake restart pre");
        expect_at(c0 + LIMIT / 2 + 1 + LIMIT, 1, 5'd22, "R9 wake restart fire");
        idle(LIMIT + 2);
        wfi_wait = 1'b0;
        idle(2);

        // R9: abandon restarts
        @(negedge clk);
        wfi_wait = 1'b1;
        c0 = cyc;
        idle(LIMIT - 3);
        wfi_wait = 1'b0;
        @(negedge clk);
        wfi_wait = 1'b1;
        expect_at(c0 + LIMIT, 0, 5'd0, "R9 abandon restart early");
        expect_at(c0 + LIMIT - 2 + LIMIT, 1, 5'd22, "R9 abandon restart fire");
        idle(LIMIT + 2);
        wfi_wait = 1'b0;
        idle(2);

        // R10: static rule wins over simultaneous timer expiry
        set_ctl(3'd5, 0, 1, 1, 0, 0);
        @(negedge clk);
        wfi_wait = 1'b1;
        c0 = cyc;
        idle(LIMIT - 1);
        op_valid = 1'b1;
        op_class = 3'd3;
        expect_at(c0 + LIMIT, 1, 5'd22, "R10 merged single report");
        expect_at(c0 + LIMIT + 1, 0, 5'd0, "R10 cause cleared");
        @(negedge clk);
        op_valid = 1'b0;
        idle(2);
        wfi_wait = 1'b0;
        set_ctl(3'd0, 0, 0, 0, 0, 0);
        issue(3'd0, 0, 5'd0, "R10 other class quiet");

        idle(4);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending, expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule